// File: doc/BRIEF.md
# Double-Word Output FIFO with Hysteresis Flags

This block buffers formatted video and sliced-data words on their way to a narrow output port. Upstream logic writes 32-bit double words with a valid strobe. The read side unpacks each stored word into beats on a 16-bit data output. The beat width is set by a mode input: either two 16-bit halves, or four bytes carried on the low byte lane. A qualifier output marks every cycle that carries a real beat.

Three flags describe the fill state. An almost-empty flag compares the level with one of three selectable thresholds. A "filled" flag sets at a programmable high-water mark. It then stays set until the level drops below the almost-empty threshold, which gives the downstream consumer a wide hysteresis band. A sticky overflow flag records any write that found the buffer full. One status pin can show a constant zero, the filled flag or the overflow flag, with a selectable inversion.

Top module: `dword_out_fifo`

## Requirements
- R1: After reset, almostEmpty=1, filled=0, overflow=0 and outQual=0, and statPin equals statInv for any selection that shows a flag.
- R2: With byteMode=0, each stored word is sent as two beats: bits 15:0 first, then bits 31:16. Words leave in the order they were written.
- R3: With byteMode=1, each word is sent as four beats on outData[7:0], byte 0 (bits 7:0) first, with outData[15:8]=0.
- R4: outQual equals rdEn while the FIFO holds at least one word, and is 0 when it is empty. A beat is consumed only on a qualified cycle, so with rdEn=0 outData holds the same beat.
- R5: almostEmpty is 1 when the level in words is below 16 (aeSel=0), below 8 (aeSel=1), or below 4 (aeSel=2 or 3).
- R6: filled becomes 1 at the clock edge after which the level is at least afLevel.
- R7: Once set, filled stays 1 while the level is between the almost-empty threshold and afLevel. It returns to 0 at the edge after which the level is below the almost-empty threshold.
- R8: With the level at DEPTH (default 64), a write is dropped, even if a word completes its last beat in the same cycle. The stored contents are unchanged and overflow is set.
- R9: overflow stays 1 until ovfClear is 1 at a clock edge. If a dropped write and ovfClear meet in the same cycle, overflow stays 1.
- R10: statPin = sel XOR statInv, where sel is 0 for statSel=0 or 3, filled for statSel=1, and overflow for statSel=2.
- R11: When the level is below DEPTH, a write in the same cycle as the last beat of a word leaves the level unchanged and stores the new word behind the remaining ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Write strobe for wrData |
| wrData | input | 32 | Double word to store |
| rdEn | input | 1 | Consumer takes a beat this cycle |
| byteMode | input | 1 | 0: 16-bit beats, 1: 8-bit beats |
| aeSel | input | 2 | Almost-empty threshold: 0 → 16, 1 → 8, 2/3 → 4 words |
| afLevel | input | LVL_W (7) | Level at which filled sets |
| statSel | input | 2 | Status pin source |
| statInv | input | 1 | Invert status pin |
| ovfClear | input | 1 | Clear sticky overflow |
| outData | output | 16 | Output beat |
| outQual | output | 1 | Beat on outData is valid |
| almostEmpty | output | 1 | Level below selected threshold |
| filled | output | 1 | Hysteresis fill flag |
| overflow | output | 1 | Sticky dropped-write flag |
| statPin | output | 1 | Multiplexed status pin |

## Verification
Two functions can fall in the same cycle: the write path and the completion of a word's last beat. The bench provokes this twice. First it writes on the closing beat of a word while the FIFO is partly filled. This write must be kept, and the new word must come out right after the old one. Then it writes on the closing beat while the FIFO is full. This write must be dropped and must set overflow, and a full drain must show exactly DEPTH-1 words. A dropped write is also placed in the same cycle as ovfClear, and overflow must read 1 afterwards.

// File: rtl/dofifo_pkg.sv
package dofifo_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int BYTE_W = 8;
  localparam int BEAT_W = 2;

  typedef enum logic [1:0] {
    STAT_ZERO     = 2'b00,
    STAT_FILLED   = 2'b01,
    STAT_OVF      = 2'b10,
    STAT_ZERO_ALT = 2'b11
  } statSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              push;
    logic [BEAT_W-1:0] beatSel;
    logic              byteMode;
  } fifoStrobe_t;
endpackage

// File: rtl/dofifo_dpath.sv
module dofifo_dpath
  import dofifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic              clk,
  input  fifoStrobe_t       strb,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdAddr,
  input  logic [WORD_W-1:0] wrData,
  output logic [HALF_W-1:0] outData
);
  localparam int HALVES = WORD_W / HALF_W;
  localparam int BYTES  = WORD_W / BYTE_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] head;
  logic [HALF_W-1:0] halfSlice [HALVES];
  logic [BYTE_W-1:0] byteSlice [BYTES];

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrAddr] <= wrData;
  end

  assign head = mem[rdAddr];

  genvar gi;
  generate
    for (gi = 0; gi < HALVES; gi++) begin : gHalf
      assign halfSlice[gi] = head[gi*HALF_W +: HALF_W];
    end
    for (gi = 0; gi < BYTES; gi++) begin : gByte
      assign byteSlice[gi] = head[gi*BYTE_W +: BYTE_W];
    end
  endgenerate

  always_comb begin
    if (strb.byteMode)
      outData = {{(HALF_W-BYTE_W){1'b0}}, byteSlice[strb.beatSel]};
    else
      outData = halfSlice[strb.beatSel[0]];
  end
endmodule

// File: rtl/dofifo_ctrl.sv
module dofifo_ctrl
  import dofifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic             rdEn,
  input  logic             byteMode,
  input  logic [1:0]       aeSel,
  input  logic [LVL_W-1:0] afLevel,
  input  logic [1:0]       statSel,
  input  logic             statInv,
  input  logic             ovfClear,
  output fifoStrobe_t      strb,
  output logic [AW-1:0]    wrAddr,
  output logic [AW-1:0]    rdAddr,
  output logic             outQual,
  output logic             almostEmpty,
  output logic             filled,
  output logic             overflow,
  output logic             statPin
);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

  logic [LVL_W-1:0]  cntQ, cntNext, aeThr;
  logic [AW-1:0]     wpQ, rpQ;
  logic [BEAT_W-1:0] beatQ;
  logic              filledQ, ovfQ;
  logic              full, empty, pushOk, dropW, lastBeat, popWord;
  statSel_e          selE;
  logic              selBit;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (cntQ == LVL_FULL);
  assign empty    = (cntQ == '0);
  assign pushOk   = wrValid && !full;
  assign dropW    = wrValid && full;
  assign outQual  = rdEn && !empty;
  assign lastBeat = byteMode ? (beatQ == 2'd3) : beatQ[0];
  assign popWord  = outQual && lastBeat;

  always_comb begin
    case (aeSel)
      2'd0:    aeThr = LVL_W'(16);
      2'd1:    aeThr = LVL_W'(8);
      default: aeThr = LVL_W'(4);
    endcase
  end

  always_comb begin
    case ({pushOk, popWord})
      2'b10:   cntNext = cntQ + 1'b1;
      2'b01:   cntNext = cntQ - 1'b1;
      default: cntNext = cntQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ    <= '0;
      wpQ     <= '0;
      rpQ     <= '0;
      beatQ   <= '0;
      filledQ <= 1'b0;
      ovfQ    <= 1'b0;
    end else begin
      cntQ <= cntNext;
      if (pushOk)  wpQ <= nextPtr(wpQ);
      if (popWord) rpQ <= nextPtr(rpQ);
      if (outQual) beatQ <= lastBeat ? '0 : beatQ + 1'b1;
      if (cntNext >= afLevel)   filledQ <= 1'b1;
      else if (cntNext < aeThr) filledQ <= 1'b0;
      if (dropW)         ovfQ <= 1'b1;
      else if (ovfClear) ovfQ <= 1'b0;
    end
  end

  assign selE = statSel_e'(statSel);
  always_comb begin
    case (selE)
      STAT_FILLED: selBit = filledQ;
      STAT_OVF:    selBit = ovfQ;
      default:     selBit = 1'b0;
    endcase
  end

  assign statPin       = selBit ^ statInv;
  assign almostEmpty   = (cntQ < aeThr);
  assign filled        = filledQ;
  assign overflow      = ovfQ;
  assign wrAddr        = wpQ;
  assign rdAddr        = rpQ;
  assign strb.push     = pushOk;
  assign strb.beatSel  = beatQ;
  assign strb.byteMode = byteMode;

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= LVL_FULL); // R8
  AST_DROP_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && full && !outQual) |=> $stable(cntQ)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !ovfClear) |=> overflow); // R9
  AST_OVF_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && full) |=> overflow); // R9
  AST_FILLED_AT_MARK: assert property (@(posedge clk) disable iff (!rstN)
    (afLevel != '0 && cntQ >= afLevel && $stable(afLevel)) |-> filled); // R6
  AST_FILLED_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ < aeThr && cntQ < afLevel && $stable(aeSel) && $stable(afLevel)) |-> !filled); // R7
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !outQual |=> $stable(beatQ)); // R4
endmodule

// File: rtl/dword_out_fifo.sv
module dword_out_fifo
  import dofifo_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = ($clog2(DEPTH+1) > 5) ? $clog2(DEPTH+1) : 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic [31:0]      wrData,
  input  logic             rdEn,
  input  logic             byteMode,
  input  logic [1:0]       aeSel,
  input  logic [LVL_W-1:0] afLevel,
  input  logic [1:0]       statSel,
  input  logic             statInv,
  input  logic             ovfClear,
  output logic [15:0]      outData,
  output logic             outQual,
  output logic             almostEmpty,
  output logic             filled,
  output logic             overflow,
  output logic             statPin
);
  fifoStrobe_t   strb;
  logic [AW-1:0] wrAddr, rdAddr;

  dofifo_ctrl #(.DEPTH(DEPTH), .AW(AW), .LVL_W(LVL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .rdEn(rdEn),
    .byteMode(byteMode), .aeSel(aeSel), .afLevel(afLevel),
    .statSel(statSel), .statInv(statInv), .ovfClear(ovfClear),
    .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .outQual(outQual), .almostEmpty(almostEmpty), .filled(filled),
    .overflow(overflow), .statPin(statPin)
  );

  dofifo_dpath #(.DEPTH(DEPTH), .AW(AW)) uDpath (
    .clk(clk), .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .outData(outData)
  );
endmodule

// File: tb/sim_dword_out_fifo.sv
module sim_dword_out_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int LVL_W = ($clog2(DEPTH+1) > 5) ? $clog2(DEPTH+1) : 5;
  localparam int NVEC = 6;
  // {byteMode, word}
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b0, 32'h1234_5678}, {1'b1, 32'hA1B2_C3D4}, {1'b0, 32'hFFFF_0000},
    {1'b1, 32'h0000_00FF}, {1'b1, 32'h8001_7E42}, {1'b0, 32'hCAFE_F00D}
  };

  logic clk = 1'b0;
  logic rstN, wrValid, rdEn, byteMode, statInv, ovfClear;
  logic [31:0] wrData;
  logic [1:0] aeSel, statSel;
  logic [LVL_W-1:0] afLevel;
  logic [15:0] outData;
  logic outQual, almostEmpty, filled, overflow, statPin;

  int nChecks = 0;
  int nFail = 0;
  logic [31:0] q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dword_out_fifo #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData), .rdEn(rdEn),
    .byteMode(byteMode), .aeSel(aeSel), .afLevel(afLevel), .statSel(statSel),
    .statInv(statInv), .ovfClear(ovfClear), .outData(outData), .outQual(outQual),
    .almostEmpty(almostEmpty), .filled(filled), .overflow(overflow), .statPin(statPin)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic wv, input logic [31:0] wd, input logic rd, input logic clr);
    @(negedge clk);
    wrValid = wv; wrData = wd; rdEn = rd; ovfClear = clr;
    #1;
  endtask

  task automatic settle();
    drive(1'b0, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic pushW(input logic [31:0] d);
    drive(1'b1, d, 1'b0, 1'b0);
    if (q.size() < DEPTH) q.push_back(d);
  endtask

  function automatic logic [31:0] beatOf(input logic [31:0] w, input int b, input logic bm);
    return bm ? {24'h0, w[8*b +: 8]} : {16'h0, w[16*b +: 16]};
  endfunction

  task automatic popWord(input string req);
    logic [31:0] w;
    w = q.pop_front();
    for (int b = 0; b < (byteMode ? 4 : 2); b++) begin
      drive(1'b0, 32'h0, 1'b1, 1'b0);
      check(req, {31'h0, outQual}, 32'h1);
      check(req, {16'h0, outData}, beatOf(w, b, byteMode));
    end
  endtask

  task automatic finish();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    logic [31:0] w1, w2;
    rstN = 1'b0; wrValid = 1'b0; wrData = '0; rdEn = 1'b1; byteMode = 1'b0;
    aeSel = 2'd0; afLevel = LVL_W'(12); statSel = 2'd1; statInv = 1'b1; ovfClear = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 almostEmpty", {31'h0, almostEmpty}, 32'h1);
    check("R1 filled", {31'h0, filled}, 32'h0);
    check("R1 overflow", {31'h0, overflow}, 32'h0);
    check("R1 outQual", {31'h0, outQual}, 32'h0);
    check("R1 statPin", {31'h0, statPin}, 32'h1);
    rstN = 1'b1; rdEn = 1'b0; statInv = 1'b0;

    // vector table: R2 / R3 / R4
    for (int i = 0; i < NVEC; i++) begin
      byteMode = VEC[i][32];
      pushW(VEC[i][31:0]);
      popWord(byteMode ? "R3 byte beats" : "R2 half beats");
      drive(1'b0, 32'h0, 1'b1, 1'b0);
      check("R4 qual empty", {31'h0, outQual}, 32'h0);
    end

    // R4 hold with rdEn low
    byteMode = 1'b0;
    pushW(32'h5566_7788);
    settle();
    check("R4 hold qual", {31'h0, outQual}, 32'h0);
    check("R4 hold data", {16'h0, outData}, 32'h7788);
    settle();
    check("R4 hold data2", {16'h0, outData}, 32'h7788);
    popWord("R4 after hold");

    // R5 thresholds
    aeSel = 2'd1;
    for (int i = 0; i < 7; i++) pushW(32'h100 + i);
    settle();
    check("R5 7 below 8", {31'h0, almostEmpty}, 32'h1);
    pushW(32'h107);
    settle();
    check("R5 8 not below 8", {31'h0, almostEmpty}, 32'h0);
    aeSel = 2'd2; #1;
    check("R5 8 vs 4", {31'h0, almostEmpty}, 32'h0);
    aeSel = 2'd0; #1;
    check("R5 8 vs 16", {31'h0, almostEmpty}, 32'h1);
    aeSel = 2'd3; #1;
    check("R5 sel3 is 4", {31'h0, almostEmpty}, 32'h0);

    // R6 / R7 hysteresis, R10 filled on pin
    aeSel = 2'd2; afLevel = LVL_W'(12);
    for (int i = 8; i < 11; i++) pushW(32'h100 + i);
    settle();
    check("R6 11 below mark", {31'h0, filled}, 32'h0);
    pushW(32'h10B);
    settle();
    check("R6 reached mark", {31'h0, filled}, 32'h1);
    statSel = 2'd1; statInv = 1'b0; #1;
    check("R10 pin filled", {31'h0, statPin}, 32'h1);
    for (int i = 0; i < 8; i++) popWord("R7 drain data");
    settle();
    check("R7 held at 4", {31'h0, filled}, 32'h1);
    popWord("R7 drain data");
    settle();
    check("R7 cleared at 3", {31'h0, filled}, 32'h0);
    for (int i = 0; i < 3; i++) popWord("R7 drain data");

    // R8 overflow
    for (int i = 0; i < DEPTH; i++) pushW(32'hB000_0000 + i);
    settle();
    check("R8 no ovf at full", {31'h0, overflow}, 32'h0);
    pushW(32'hDEAD_0001);
    settle();
    check("R8 ovf set", {31'h0, overflow}, 32'h1);
    statSel = 2'd2; #1;
    check("R10 pin ovf", {31'h0, statPin}, 32'h1);
    statInv = 1'b1; #1;
    check("R10 pin ovf inv", {31'h0, statPin}, 32'h0);
    statSel = 2'd3; #1;
    check("R10 pin zero inv", {31'h0, statPin}, 32'h1);
    statSel = 2'd0; statInv = 1'b0; #1;
    check("R10 pin zero", {31'h0, statPin}, 32'h0);
    byteMode = 1'b1;
    for (int i = 0; i < DEPTH; i++) popWord("R8 contents");
    drive(1'b0, 32'h0, 1'b1, 1'b0);
    check("R8 nothing extra", {31'h0, outQual}, 32'h0);
    check("R9 sticky", {31'h0, overflow}, 32'h1);
    drive(1'b0, 32'h0, 1'b0, 1'b1);
    settle();
    check("R9 cleared", {31'h0, overflow}, 32'h0);

    // R9 set beats clear
    for (int i = 0; i < DEPTH; i++) pushW(32'hC000_0000 + i);
    drive(1'b1, 32'hDEAD_0002, 1'b0, 1'b1);
    settle();
    check("R9 set wins", {31'h0, overflow}, 32'h1);
    drive(1'b0, 32'h0, 1'b0, 1'b1);
    settle();
    check("R9 cleared again", {31'h0, overflow}, 32'h0);

    // R8 full + last beat + write: dropped
    byteMode = 1'b0;
    w1 = q.pop_front();
    drive(1'b0, 32'h0, 1'b1, 1'b0);
    check("R8 beat0", {16'h0, outData}, {16'h0, w1[15:0]});
    drive(1'b1, 32'hDEAD_0003, 1'b1, 1'b0);
    check("R8 beat1", {16'h0, outData}, {16'h0, w1[31:16]});
    settle();
    check("R8 ovf on pop+write", {31'h0, overflow}, 32'h1);
    for (int i = 0; i < DEPTH-1; i++) popWord("R8 drain after drop");
    drive(1'b0, 32'h0, 1'b1, 1'b0);
    check("R8 write was dropped", {31'h0, outQual}, 32'h0);
    drive(1'b0, 32'h0, 1'b0, 1'b1);

    // R11 write with last beat, not full
    w1 = 32'h1111_2222; w2 = 32'h3333_4444;
    pushW(w1);
    void'(q.pop_front());
    drive(1'b0, 32'h0, 1'b1, 1'b0);
    check("R11 w1 low", {16'h0, outData}, 32'h2222);
    drive(1'b1, w2, 1'b1, 1'b0);
    check("R11 w1 high", {16'h0, outData}, 32'h1111);
    q.push_back(w2);
    settle();
    check("R11 level one", {31'h0, outQual | almostEmpty}, 32'h1);
    popWord("R11 new word");
    drive(1'b0, 32'h0, 1'b1, 1'b0);
    check("R11 empty after", {31'h0, outQual}, 32'h0);

    settle();
    finish();
  end
endmodule